// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block sits between the PWM modulator of one converter phase and that phase's two gate drivers. It turns a single PWM request into two gate enables, one for the high-side switch and one for the low-side switch, and it never lets them overlap. Before either switch is turned on, the block waits until the opposite switch is known to be off. For the low side, that evidence is a digitized comparator reporting that the switch node has fallen below its threshold. For the high side, it is a comparator reporting that the low-side gate voltage has dropped below its threshold. After that evidence arrives, a short fixed guard count still has to run out.

With negative inductor current, the switch node may never fall after the high side releases. A timeout therefore turns the low side on anyway, once a fixed number of cycles has passed since the high side went off. Two override inputs take precedence over the normal sequencing. The first clamps the low side on and the high side off, for overvoltage crowbar and pre-start discharge. The second forces both switches off, and it outranks the first. Both comparator inputs are asynchronous, so each passes through a synchronizer of configurable depth. All delays are parameters in clock cycles, and their defaults are derived from a clock period and delay times given in picoseconds.

The controller is a Moore machine with eight states:
- `ST_OFF`: both switches off; entered at reset or under force-off.
- `ST_HS_ON`: high side conducting.
- `ST_WAIT_SW`: high side released; waiting for the switch node to fall or for the timeout.
- `ST_DLY_LS`: guard count running before the low side turns on.
- `ST_LS_ON`: low side conducting.
- `ST_WAIT_LG`: low side released; waiting for its gate to discharge.
- `ST_DLY_HS`: guard count running before the high side turns on.
- `ST_FORCE_LS`: low side clamped on by the override.

The transitions are:
- Force-off moves every state to `ST_OFF`.
- Force-low-side, when force-off is not asserted, moves every state to `ST_FORCE_LS`.
- When neither override is asserted, `ST_OFF` goes to `ST_WAIT_LG` if PWM is high and to `ST_WAIT_SW` if it is low.
- When neither override is asserted, `ST_FORCE_LS` goes to `ST_WAIT_LG` if PWM is high and to `ST_LS_ON` if it is low.
- `ST_HS_ON` goes to `ST_WAIT_SW` when PWM falls.
- `ST_WAIT_SW` goes to `ST_WAIT_LG` on a PWM reversal. Otherwise it goes to `ST_DLY_LS` on a synchronized node-low indication. Failing both, it goes to `ST_LS_ON` when the timeout expires.
- `ST_DLY_LS` goes to `ST_WAIT_LG` on a reversal, or to `ST_LS_ON` when its count ends.
- `ST_LS_ON` goes to `ST_WAIT_LG` when PWM rises.
- `ST_WAIT_LG` goes to `ST_WAIT_SW` on a reversal, or to `ST_DLY_HS` on a synchronized gate-low indication.
- `ST_DLY_HS` goes to `ST_WAIT_SW` on a reversal, or to `ST_HS_ON` when its count ends.

Top module: `gate_deadtime_ctrl`

## Requirements
- R1: With the node comparator already synchronized high, `ls_en` rises DEAD_CYC+1 clock edges after the edge at which `hs_en` fell.
- R2: With the low-gate comparator already synchronized high, `hs_en` rises DEAD_CYC+1 clock edges after the edge at which `ls_en` fell.
- R3: If the node comparator stays low, `ls_en` rises WDOG_CYC edges after `hs_en` fell. The defaults give DEAD_CYC=8 and WDOG_CYC=60 at a 4000 ps clock.
- R4: `hs_en` and `ls_en` are never high in the same cycle.
- R5: Suppose PWM reverses while a turn-on is still pending, in a wait or guard state. Then the pending switch never turns on, and the other switch is sequenced through its own wait and guard count.
- R6: While `force_ls` is high and `force_off` is low, from the next edge on `ls_en` is 1 and `hs_en` is 0.
- R7: While `force_off` is high, from the next edge on both enables are 0, whatever `force_ls` is.
- R8: While reset is asserted, both enables are 0.
- R9: Each comparator input is seen by the sequencer SYNC_STAGES edges after it is sampled (default 2). A node-low indication that is first driven K cycles after the PWM fall therefore turns the low side on K+SYNC_STAGES+DEAD_CYC edges after `hs_en` fell.
- R10: When `force_ls` is released with PWM low, `ls_en` stays high without a gap. When it is released with PWM high, `ls_en` falls at the next edge, and `hs_en` follows DEAD_CYC+1 edges later if the gate comparator is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_req | input | 1 | PWM request: 1 asks for the high side, 0 for the low side |
| node_low | input | 1 | Asynchronous comparator: switch node below its threshold |
| lsgate_low | input | 1 | Asynchronous comparator: low-side gate below its threshold |
| force_ls | input | 1 | Override: clamp the low side on and the high side off |
| force_off | input | 1 | Override: both switches off; outranks `force_ls` |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The interesting collision is the timeout expiring in the same cycle that a synchronized node-low indication or a PWM reversal arrives. In `ST_WAIT_SW` the three events are resolved in a fixed priority: reversal first, then comparator, then timeout. Random stimulus provokes the collision by alternating between phases where the node comparator toggles slowly, so the timeout fires, and phases where it toggles quickly. Overrides are mixed in at random moments. A cycle-level bench model applies the same priority, and every cycle is judged by comparing both enables against that model.

// File: rtl/gdt_pkg.sv
package gdt_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_HS_ON    = 3'd1,
        ST_WAIT_SW  = 3'd2,
        ST_DLY_LS   = 3'd3,
        ST_LS_ON    = 3'd4,
        ST_WAIT_LG  = 3'd5,
        ST_DLY_HS   = 3'd6,
        ST_FORCE_LS = 3'd7
    } gdt_state_e;

    // Round a time up to a whole number of clock periods (at least one).
    function automatic int ceil_div(input int num, input int den);
        int q;
        q = (num + den - 1) / den;
        return (q < 1) ? 1 : q;
    endfunction

endpackage

// File: rtl/gdt_sync.sv
module gdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else if (STAGES == 1) begin : g_single
            logic q_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q_r <= 1'b0;
                end else begin
                    q_r <= d;
                end
            end
            assign q = q_r;
        end else begin : g_chain
            logic [STAGES-1:0] pipe_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_r <= '0;
                end else begin
                    pipe_r <= {pipe_r[STAGES-2:0], d};
                end
            end
            assign q = pipe_r[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/gdt_timer.sv
module gdt_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);

    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LAST);

    // R3 support: the count never passes its terminal value
    a_r3_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && done) |=> done);

endmodule

// File: rtl/gdt_fsm.sv
module gdt_fsm
    import gdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req,
    input  logic node_low_s,
    input  logic lsgate_low_s,
    input  logic force_ls,
    input  logic force_off,
    input  logic guard_done,
    input  logic wdog_done,
    output logic timer_clr,
    output logic guard_en,
    output logic wdog_en,
    output logic hs_en,
    output logic ls_en
);

    gdt_state_e state_q;
    gdt_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Transition selection
    always_comb begin
        state_d = state_q;
        if (force_off) begin
            state_d = ST_OFF;
        end else if (force_ls) begin
            state_d = ST_FORCE_LS;
        end else begin
            unique case (state_q)
                ST_OFF:      state_d = pwm_req ? ST_WAIT_LG : ST_WAIT_SW;
                ST_FORCE_LS: state_d = pwm_req ? ST_WAIT_LG : ST_LS_ON;
                ST_HS_ON: begin
                    if (!pwm_req) state_d = ST_WAIT_SW;
                end
                ST_WAIT_SW: begin
                    if (pwm_req)         state_d = ST_WAIT_LG;
                    else if (node_low_s) state_d = ST_DLY_LS;
                    else if (wdog_done)  state_d = ST_LS_ON;
                end
                ST_DLY_LS: begin
                    if (pwm_req)         state_d = ST_WAIT_LG;
                    else if (guard_done) state_d = ST_LS_ON;
                end
                ST_LS_ON: begin
                    if (pwm_req) state_d = ST_WAIT_LG;
                end
                ST_WAIT_LG: begin
                    if (!pwm_req)          state_d = ST_WAIT_SW;
                    else if (lsgate_low_s) state_d = ST_DLY_HS;
                end
                ST_DLY_HS: begin
                    if (!pwm_req)        state_d = ST_WAIT_SW;
                    else if (guard_done) state_d = ST_HS_ON;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    assign timer_clr = (state_d != state_q);

    // Moore outputs
    always_comb begin
        hs_en    = 1'b0;
        ls_en    = 1'b0;
        guard_en = 1'b0;
        wdog_en  = 1'b0;
        unique case (state_q)
            ST_HS_ON:    hs_en    = 1'b1;
            ST_LS_ON:    ls_en    = 1'b1;
            ST_FORCE_LS: ls_en    = 1'b1;
            ST_DLY_LS:   guard_en = 1'b1;
            ST_DLY_HS:   guard_en = 1'b1;
            ST_WAIT_SW:  wdog_en  = 1'b1;
            default: ;
        endcase
    end

    a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    a_r1_ls_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ls_en) && !$past(force_ls)) |-> !$past(hs_en));

    a_r2_hs_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> !$past(ls_en));

    a_r3_timeout_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_SW && !pwm_req && !node_low_s && wdog_done
         && !force_ls && !force_off) |=> ls_en);

    a_r5_cancel_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT_SW || state_q == ST_DLY_LS) && pwm_req
         && !force_ls && !force_off) |=> (state_q == ST_WAIT_LG && !ls_en));

    a_r5_cancel_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT_LG || state_q == ST_DLY_HS) && !pwm_req
         && !force_ls && !force_off) |=> (state_q == ST_WAIT_SW && !hs_en));

    a_r6_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ls && !force_off) |=> (ls_en && !hs_en));

    a_r7_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> (!hs_en && !ls_en));

endmodule

// File: rtl/gate_deadtime_ctrl.sv
module gate_deadtime_ctrl
    import gdt_pkg::*;
#(
    parameter int CLK_PS      = 4000,
    parameter int GUARD_PS    = 30000,
    parameter int TIMEOUT_PS  = 240000,
    parameter int DEAD_CYC    = gdt_pkg::ceil_div(GUARD_PS, CLK_PS),
    parameter int WDOG_CYC    = gdt_pkg::ceil_div(TIMEOUT_PS, CLK_PS),
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req,
    input  logic node_low,
    input  logic lsgate_low,
    input  logic force_ls,
    input  logic force_off,
    output logic hs_en,
    output logic ls_en
);

    logic node_low_s;
    logic lsgate_low_s;
    logic timer_clr;
    logic guard_en;
    logic wdog_en;
    logic guard_done;
    logic wdog_done;

    gdt_sync #(.STAGES(SYNC_STAGES)) u_sync_node (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (node_low),
        .q     (node_low_s)
    );

    gdt_sync #(.STAGES(SYNC_STAGES)) u_sync_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lsgate_low),
        .q     (lsgate_low_s)
    );

    gdt_timer #(.LIMIT(DEAD_CYC)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .en    (guard_en),
        .done  (guard_done)
    );

    gdt_timer #(.LIMIT(WDOG_CYC)) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .en    (wdog_en),
        .done  (wdog_done)
    );

    gdt_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwm_req      (pwm_req),
        .node_low_s   (node_low_s),
        .lsgate_low_s (lsgate_low_s),
        .force_ls     (force_ls),
        .force_off    (force_off),
        .guard_done   (guard_done),
        .wdog_done    (wdog_done),
        .timer_clr    (timer_clr),
        .guard_en     (guard_en),
        .wdog_en      (wdog_en),
        .hs_en        (hs_en),
        .ls_en        (ls_en)
    );

endmodule

// File: tb/gate_deadtime_ctrl_tb.sv
`timescale 1ns/1ps
module gate_deadtime_ctrl_tb;

    localparam int CLK_PS = 4000;
    localparam int DEAD   = (30000 + CLK_PS - 1) / CLK_PS;
    localparam int WDOG   = (240000 + CLK_PS - 1) / CLK_PS;
    localparam int SYNC   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_req = 1'b0;
    logic node_low = 1'b0;
    logic lsgate_low = 1'b0;
    logic force_ls = 1'b0;
    logic force_off = 1'b0;
    logic hs_en;
    logic ls_en;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gate_deadtime_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_req    (pwm_req),
        .node_low   (node_low),
        .lsgate_low (lsgate_low),
        .force_ls   (force_ls),
        .force_off  (force_off),
        .hs_en      (hs_en),
        .ls_en      (ls_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model. Phases: 0 idle, 1 high on, 2 wait node, 3 guard low,
    // 4 low on, 5 wait gate, 6 guard high, 7 clamped low
    int m_ph = 0;
    int m_cnt = 0;
    int m_nx;
    logic [SYNC-1:0] m_np = '0;
    logic [SYNC-1:0] m_gp = '0;
    logic m_nv, m_gv;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_np = '0; m_gp = '0;
        end else begin
            m_nv = m_np[SYNC-1];
            m_gv = m_gp[SYNC-1];
            m_np = {m_np[SYNC-2:0], node_low};
            m_gp = {m_gp[SYNC-2:0], lsgate_low};
            m_nx = m_ph;
            if (force_off) m_nx = 0;
            else if (force_ls) m_nx = 7;
            else case (m_ph)
                0: m_nx = pwm_req ? 5 : 2;
                7: m_nx = pwm_req ? 5 : 4;
                1: if (!pwm_req) m_nx = 2;
                2: if (pwm_req) m_nx = 5; else if (m_nv) m_nx = 3;
                   else if (m_cnt == WDOG - 1) m_nx = 4;
                3: if (pwm_req) m_nx = 5; else if (m_cnt == DEAD - 1) m_nx = 4;
                4: if (pwm_req) m_nx = 5;
                5: if (!pwm_req) m_nx = 2; else if (m_gv) m_nx = 6;
                6: if (!pwm_req) m_nx = 2; else if (m_cnt == DEAD - 1) m_nx = 1;
                default: m_nx = 0;
            endcase
            if (m_nx != m_ph) m_cnt = 0; else m_cnt++;
            m_ph = m_nx;
        end
    end

    always @(negedge clk) begin
        logic eh, el;
        eh = (m_ph == 1);
        el = (m_ph == 4 || m_ph == 7);
        chk({hs_en, ls_en} === {eh, el}, "R1/R2/R3/R5 model", {hs_en, ls_en}, {eh, el});
        chk(!(hs_en && ls_en), "R4", {hs_en, ls_en}, 0);
    end

    task automatic wait_rise(input bit pick_hs, output int gap, output bit saw_other);
        int n = 0;
        saw_other = 1'b0;
        do begin
            @(negedge clk);
            n++;
            if (pick_hs ? ls_en : hs_en) saw_other = 1'b1;
        end while (!(pick_hs ? hs_en : ls_en) && n < 1000);
        gap = n - 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL timeout all-requirements actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int gap;
        bit other;
        void'($urandom(32'h1A2B3C));
        repeat (5) begin
            @(negedge clk);
            chk(!hs_en && !ls_en, "R8", {hs_en, ls_en}, 0);
        end
        rst_n = 1'b1;

        // R1: node already low
        pwm_req = 1'b1; lsgate_low = 1'b1; node_low = 1'b1;
        repeat (30) @(negedge clk);
        chk(hs_en, "R2 setup", hs_en, 1);
        pwm_req = 1'b0;
        wait_rise(1'b0, gap, other);
        chk(gap == DEAD + 1, "R1", gap, DEAD + 1);

        // R2: gate already low
        repeat (10) @(negedge clk);
        pwm_req = 1'b1;
        wait_rise(1'b1, gap, other);
        chk(gap == DEAD + 1, "R2", gap, DEAD + 1);

        // R9: node indication arrives late
        repeat (10) @(negedge clk);
        node_low = 1'b0;
        repeat (10) @(negedge clk);
        pwm_req = 1'b0;
        begin
            int n = 0;
            do begin
                @(negedge clk);
                n++;
                if (n == 5) node_low = 1'b1;
            end while (!ls_en && n < 1000);
            chk(n - 1 == 5 + SYNC + DEAD, "R9", n - 1, 5 + SYNC + DEAD);
        end

        // R3: node never falls
        pwm_req = 1'b1; node_low = 1'b0;
        repeat (30) @(negedge clk);
        pwm_req = 1'b0;
        wait_rise(1'b0, gap, other);
        chk(gap == WDOG, "R3", gap, WDOG);

        // R5: reversal during low-side guard count
        pwm_req = 1'b1;
        repeat (30) @(negedge clk);
        node_low = 1'b1;
        repeat (5) @(negedge clk);
        pwm_req = 1'b0;
        repeat (3) @(negedge clk);
        pwm_req = 1'b1;
        wait_rise(1'b1, gap, other);
        chk(!other, "R5 low stays off", other, 0);
        chk(gap == DEAD + 1, "R5 high resequenced", gap, DEAD + 1);

        // R5: reversal while waiting for gate discharge
        pwm_req = 1'b0;
        repeat (30) @(negedge clk);
        lsgate_low = 1'b0;
        repeat (5) @(negedge clk);
        pwm_req = 1'b1;
        repeat (3) @(negedge clk);
        pwm_req = 1'b0;
        wait_rise(1'b0, gap, other);
        chk(!other, "R5 high stays off", other, 0);
        chk(gap == DEAD + 1, "R5 low resequenced", gap, DEAD + 1);

        // R6: clamp from high side
        lsgate_low = 1'b1; pwm_req = 1'b1;
        repeat (30) @(negedge clk);
        force_ls = 1'b1;
        repeat (10) begin
            @(negedge clk);
            chk(ls_en && !hs_en, "R6", {hs_en, ls_en}, 1);
        end

        // R7: force-off outranks clamp
        force_off = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk(!ls_en && !hs_en, "R7", {hs_en, ls_en}, 0);
        end

        // R10: release with PWM low keeps low side
        force_off = 1'b0; pwm_req = 1'b0;
        repeat (5) @(negedge clk);
        force_ls = 1'b0;
        repeat (6) begin
            @(negedge clk);
            chk(ls_en, "R10 low held", ls_en, 1);
        end

        // R10: release with PWM high
        force_ls = 1'b1; pwm_req = 1'b1;
        repeat (3) @(negedge clk);
        force_ls = 1'b0;
        @(negedge clk);
        chk(!ls_en && !hs_en, "R10 low drops", {hs_en, ls_en}, 0);
        begin
            int n = 1;
            while (!hs_en && n < 1000) begin
                @(negedge clk);
                n++;
            end
            chk(n - 1 == DEAD + 1, "R10 high follows", n - 1, DEAD + 1);
        end

        // Random phase; slow node mode lets the timeout collide with arrivals
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if ($urandom_range(39) == 0) pwm_req = ~pwm_req;
            if ($urandom_range(((i / 1000) % 2 == 1) ? 70 : 6) == 0) node_low = ~node_low;
            if ($urandom_range(7) == 0) lsgate_low = ~lsgate_low;
            if ($urandom_range(force_ls ? 15 : 299) == 0) force_ls = ~force_ls;
            if ($urandom_range(force_off ? 7 : 499) == 0) force_off = ~force_off;
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule